// File: doc/BRIEF.md
# Clock Buffer Output-Enable Controller over I2C

This block gates a bank of thirteen clock buffer outputs according to enable bits that a host writes over a two-wire I2C bus. It is a write-only slave. Each transfer starts with the 7-bit slave address and a write bit. A command byte and a byte-count byte follow, and then up to three data bytes.

The command and count bytes are acknowledged, but their values are never used. Data always lands in enable byte 0 first and then in ascending byte order. Some bit positions in each data byte are reserved, so the thirteen enables map onto a scattered set of bit positions.

Each output is a registered copy of its clock input while its enable bit is 1, and is held low while the bit is 0. After reset every output is enabled. SCL and SDA are sampled into the system clock domain through synchronizers. The acknowledge is given by asserting a pull-down enable for SDA.

Top module: `clkbuf_oe_i2c`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits are 1101001 and its R/W bit is 0 (sent on the wire as 0xD2). Any other address byte, including the same address with R/W = 1, is not acknowledged, and the rest of that transfer changes no enable.
- R2: The two bytes that follow the address (command, then count) are acknowledged, and their values have no effect on any enable.
- R3: After reset, all thirteen enables are 1, so every output follows its clock input.
- R4: Each output is its clock input registered by one system clock while its enable is 1, and is 0 while its enable is 0.
- R5: In data byte 0, bits 7, 6, 3, 2, 1 and 0 set the enables of outputs 5, 4, 3, 2, 1 and 0. Bits 5 and 4 are ignored.
- R6: In data byte 1, bits 7, 6, 5 and 4 set outputs 11, 10, 9 and 8, and bits 1 and 0 set outputs 7 and 6. Bits 3 and 2 are ignored.
- R7: In data byte 2, bit 6 sets output 12 and all other bits are ignored.
- R8: Bits on the wire are taken most significant first, and data bytes go to byte 0, 1 and 2 in the order they arrive.
- R9: A data byte takes effect only at the acknowledge clock of that byte. A STOP before a byte is complete leaves that byte's enables and all later bytes' enables unchanged.
- R10: Data bytes after the third are acknowledged and discarded.
- R11: A repeated START ends the current transfer. The next transfer again expects an address and writes its first data byte to byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled level of the I2C clock line |
| sda_i | input | 1 | Sampled level of the I2C data line |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| clk_in | input | 13 | Clock inputs to be gated |
| clk_out | output | 13 | Gated, registered outputs |

## Verification
The hardest cases to reach are transfers that end early: a STOP in the middle of a data byte, and a repeated START after a data byte. Both must leave the byte pointer and the enables exactly as the acknowledge rule says. The stimulus drives a bit-level bus model, so it can stop after any number of bits. It then checks the outputs against a model that applied only the fully acknowledged bytes. In the repeated-START case, the enables are first set to values for which a write that went wrongly to byte 1 would give a different output pattern from a correct write to byte 0.

// File: rtl/oe_i2c_pkg.sv
package oe_i2c_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RX   = 2'd1,
    PH_ACK  = 2'd2
  } phase_e;

  // Enable register byte that controls output o
  function automatic int out_byte(input int o);
    if (o <= 5)       return 0;
    else if (o <= 11) return 1;
    else              return 2;
  endfunction

  // Bit inside that byte that controls output o; reserved positions are skipped
  function automatic int out_bit(input int o);
    case (o)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4: return 6;
      5: return 7;
      6: return 0;
      7: return 1;
      8: return 4;
      9: return 5;
      10: return 6;
      11: return 7;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_blockwr_slave.sv
module i2c_blockwr_slave
  import oe_i2c_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int DATA_BYTES = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_pull,
  output logic             wr_stb,
  output logic [SEL_W-1:0] wr_sel,
  output logic [7:0]       wr_data
);

  localparam int HDR_BYTES = 3;                       // address, command, count
  localparam int IDX_MAX   = HDR_BYTES + DATA_BYTES;  // saturating "discard" index
  localparam int IDX_W     = $clog2(IDX_MAX + 1);

  phase_e           phase;
  logic [3:0]       bitcnt;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       shreg;
  logic             addr_ok, is_data;
  logic [IDX_W-1:0] data_off;

  assign addr_ok  = (shreg[7:1] == SLAVE_ADDR) && !shreg[0];
  assign is_data  = (byte_idx >= IDX_W'(HDR_BYTES)) && (byte_idx < IDX_W'(IDX_MAX));
  assign data_off = byte_idx - IDX_W'(HDR_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bitcnt   <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      sda_pull <= 1'b0;
      wr_stb   <= 1'b0;
      wr_sel   <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (stop_det) begin
        phase    <= PH_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        phase    <= PH_RX;
        bitcnt   <= '0;
        byte_idx <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (phase)
          PH_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (byte_idx != '0 || addr_ok) begin
                sda_pull <= 1'b1;
                phase    <= PH_ACK;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          PH_ACK: begin
            if (scl_rise) begin
              if (is_data) begin
                wr_stb  <= 1'b1;
                wr_sel  <= data_off[SEL_W-1:0];
                wr_data <= shreg;
              end
            end else if (scl_fall) begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              phase    <= PH_RX;
              if (byte_idx != IDX_W'(IDX_MAX)) byte_idx <= byte_idx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/oe_gate_bank.sv
module oe_gate_bank #(
  parameter int NUM_OUT = 13,
  parameter int SEL_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [7:0]         wr_data,
  input  logic [NUM_OUT-1:0] clk_in,
  output logic [NUM_OUT-1:0] en,
  output logic [NUM_OUT-1:0] clk_out
);

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_en
    localparam int BYTE_SEL = oe_i2c_pkg::out_byte(o);
    localparam int BIT_SEL  = oe_i2c_pkg::out_bit(o);
    always_ff @(posedge clk) begin
      if (rst) en[o] <= 1'b1;
      else if (wr_stb && wr_sel == SEL_W'(BYTE_SEL)) en[o] <= wr_data[BIT_SEL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clk_out <= '0;
    else     clk_out <= clk_in & en;
  end

endmodule

// File: rtl/clkbuf_oe_i2c.sv
module clkbuf_oe_i2c #(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int NUM_OUT = 13,
  parameter int DATA_BYTES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull,
  input  logic [NUM_OUT-1:0] clk_in,
  output logic [NUM_OUT-1:0] clk_out
);

  localparam int SEL_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb;
  logic [SEL_W-1:0] wr_sel;
  logic [7:0] wr_data;
  logic [NUM_OUT-1:0] en;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_blockwr_slave #(.SLAVE_ADDR(SLAVE_ADDR), .DATA_BYTES(DATA_BYTES), .SEL_W(SEL_W)) u_slave (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_pull(sda_pull),
    .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  oe_gate_bank #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
    .clk_in(clk_in), .en(en), .clk_out(clk_out)
  );

endmodule

// File: rtl/oe_i2c_checker.sv
module oe_i2c_checker #(
  parameter int NUM_OUT = 13,
  parameter int DATA_BYTES = 3,
  parameter int SEL_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_s,
  input logic               sda_pull,
  input logic               wr_stb,
  input logic [SEL_W-1:0]   wr_sel,
  input logic [NUM_OUT-1:0] en,
  input logic [NUM_OUT-1:0] clk_out
);

  // R3: enables leave reset all set
  a_r3_reset_all_on: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (en == '1));

  // R9: enables move only after a commit strobe
  a_r9_commit_only_on_ack: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_stb) |-> $stable(en));

  // R9: a commit happens only while the acknowledge is driven
  a_r9_strobe_in_ack: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> sda_pull);

  // R1: the acknowledge pull-down begins while SCL is low
  a_r1_ack_starts_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_s);

  // R10: surplus bytes never reach the enable bank
  a_r10_sel_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (int'(wr_sel) < DATA_BYTES));

  // R4: a disabled output is low one cycle later
  a_r4_disabled_low: assert property (@(posedge clk) disable iff (rst)
    (clk_out & ~$past(en)) == '0);

endmodule

bind clkbuf_oe_i2c oe_i2c_checker #(.NUM_OUT(NUM_OUT), .DATA_BYTES(DATA_BYTES), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_pull(sda_pull),
  .wr_stb(wr_stb), .wr_sel(wr_sel), .en(en), .clk_out(clk_out)
);

// File: tb/tb_clkbuf_oe_i2c.sv
module tb_clkbuf_oe_i2c;

  localparam int N = 13;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_pull;
  logic sda_line;
  logic [N-1:0] clk_in = '0;
  logic [N-1:0] clk_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [N-1:0] model_en = '1;
  logic [N-1:0] exp_q[$];
  string tag_q[$];
  event chk_ev;

  always #4 clk = ~clk;  // 125 MHz

  assign sda_line = host_sda & ~sda_pull;

  clkbuf_oe_i2c dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_pull(sda_pull), .clk_in(clk_in), .clk_out(clk_out)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: pops expected output patterns and compares
  initial begin
    forever begin
      @(chk_ev);
      begin
        logic [N-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (clk_out !== e) begin
          n_bad++;
          $display("FAIL %s: clk_out actual=%h expected=%h", t, clk_out, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic wq(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic verify(string tag);
    logic [N-1:0] pats[2];
    pats[0] = '1;
    pats[1] = 13'h0A5A;
    foreach (pats[i]) begin
      clk_in = pats[i];
      wq(4);
      exp_q.push_back(model_en & pats[i]);
      tag_q.push_back(tag);
      ->chk_ev;
      wq(1);
    end
  endtask

  task automatic model_apply(int idx, logic [7:0] v);
    case (idx)
      0: begin
        model_en[5] = v[7]; model_en[4] = v[6]; model_en[3] = v[3];
        model_en[2] = v[2]; model_en[1] = v[1]; model_en[0] = v[0];
      end
      1: begin
        model_en[11] = v[7]; model_en[10] = v[6]; model_en[9] = v[5];
        model_en[8] = v[4]; model_en[7] = v[1]; model_en[6] = v[0];
      end
      2: model_en[12] = v[6];
      default: ;
    endcase
  endtask

  task automatic do_start();
    host_sda = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    host_sda = 1'b0; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic do_stop();
    host_sda = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    host_sda = 1'b1; wq(2 * Q);
  endtask

  task automatic send_bit(logic b);
    host_sda = b; wq(Q);
    scl = 1'b1; wq(2 * Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(logic [7:0] b, bit exp_ack, string tag);
    logic got;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    host_sda = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    got = (sda_line == 1'b0);
    n_cmp++;
    if (got !== exp_ack) begin
      n_bad++;
      $display("FAIL %s: ack actual=%0b expected=%0b (byte %h)", tag, got, exp_ack, b);
    end
    wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic header(logic [7:0] cmd, logic [7:0] cnt);
    do_start();
    send_byte(8'hD2, 1'b1, "R1");
    send_byte(cmd, 1'b1, "R2");
    send_byte(cnt, 1'b1, "R2");
  endtask

  task automatic data_byte(int idx, logic [7:0] v, string tag);
    send_byte(v, 1'b1, tag);
    model_apply(idx, v);
  endtask

  initial begin
    wq(5);
    rst = 1'b0;
    wq(5);
    verify("R3 reset all enabled");

    // all off
    header(8'hA5, 8'h3C);
    data_byte(0, 8'h00, "R4");
    data_byte(1, 8'h00, "R4");
    data_byte(2, 8'h00, "R4");
    do_stop();
    verify("R4 disabled outputs low");

    // single-bit mapping and bit order
    header(8'h00, 8'h03);
    data_byte(0, 8'h80, "R5");
    data_byte(1, 8'h01, "R6");
    data_byte(2, 8'h40, "R7");
    do_stop();
    verify("R8 msb-first byte order");

    // reserved bits only: everything off again
    header(8'hFF, 8'h00);
    data_byte(0, 8'h30, "R5");
    data_byte(1, 8'h0C, "R6");
    data_byte(2, 8'hBF, "R7");
    do_stop();
    verify("R5 R6 R7 reserved bits ignored");

    // full mapping pattern
    header(8'h12, 8'h34);
    data_byte(0, 8'h4A, "R5");
    data_byte(1, 8'hA2, "R6");
    data_byte(2, 8'h7F, "R7");
    do_stop();
    verify("R5 R6 R7 mixed pattern");

    // partial: only byte 0, then stop
    header(8'h00, 8'h00);
    data_byte(0, 8'hFF, "R9");
    do_stop();
    verify("R9 stop after byte 0");

    // stop in the middle of byte 1
    header(8'h5A, 8'hC3);
    data_byte(0, 8'h03, "R9");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    scl = 1'b0;
    do_stop();
    verify("R9 stop mid byte");

    // wrong address, then read request: no ack, no effect
    do_start();
    send_byte(8'hA4, 1'b0, "R1");
    for (int i = 0; i < 3; i++) send_byte(8'hFF, 1'b0, "R1");
    do_stop();
    do_start();
    send_byte(8'hD3, 1'b0, "R1");
    send_byte(8'hFF, 1'b0, "R1");
    do_stop();
    verify("R1 foreign or read address ignored");

    // extra data bytes acknowledged and discarded
    header(8'hFF, 8'hFF);
    data_byte(0, 8'hFF, "R10");
    data_byte(1, 8'hFF, "R10");
    data_byte(2, 8'hFF, "R10");
    send_byte(8'h00, 1'b1, "R10");
    send_byte(8'h00, 1'b1, "R10");
    do_stop();
    verify("R10 surplus bytes discarded");

    // repeated start restarts at byte 0
    header(8'h01, 8'h02);
    data_byte(0, 8'h00, "R11");
    do_start();
    send_byte(8'hD2, 1'b1, "R11");
    send_byte(8'h77, 1'b1, "R2");
    send_byte(8'h88, 1'b1, "R2");
    data_byte(0, 8'h80, "R11");
    do_stop();
    verify("R11 repeated start");

    summary();
    $finish;
  end

endmodule